// File: doc/BRIEF.md
# High-Side Switch Channel Diagnostic Controller

This block is the digital control and diagnostic logic for one channel of a smart high-side power switch. It takes a logic command and turns it into a gate enable for the power stage. It watches a set of comparator flags and reports faults on an active-low, open-drain status line. The flags are already digitized and arrive without regard to the clock. They report over-temperature, cooled-below-restart, cooled-below-status-reset, undervoltage, low current while on and output high while off. Each flag passes through a two-flop synchronizer before use.

The gate follows the command unless undervoltage or thermal shutdown forces it off. Shutdown restarts by itself once the restart flag reports cooling. The thermal status fault has its own, colder release flag. Open-load while on is reported after an on-state delay. That report is held for a fixed time after the command falls. A high output while off is reported after a delay counted from the command's falling edge. Every delay is a parameter counted in clock ticks, and a delay timer restarts whenever its condition drops out before it expires. A status-disable input releases the status pin to high impedance without stopping diagnosis.

Top module: `hsd_switch_diag`

## Requirements
- R1: While `rst_ni` is low, and for the first clock edge after it rises, `gate_o` is 0 and `stat_pull_o` is 0. Reset treats undervoltage as present.
- R2: With no flag set, `gate_o` equals `cmd_i` in the same cycle and `stat_pull_o` is 0.
- R3: An undervoltage flag forces `gate_o` to 0 and `stat_pull_o` to 0 from the second clock edge after `uv_i` rises, whatever the other inputs are.
- R4: Over-temperature forces `gate_o` to 0 from the third edge after `ot_i` rises. The gate is released again on the third edge after `ot_i` falls with `tr_i` high.
- R5: During shutdown with `cmd_i` high, status is pulled after T_SDL consecutive edges. It stays pulled while `cmd_i` is high until `trs_i` is seen, clearing on the third edge after `trs_i` rises. With `cmd_i` low, a thermal fault does not pull status.
- R6: With `cmd_i` high and `ol_on_i` high, status is pulled on edge 2+T_DOL after both rise, and not before.
- R7: After `cmd_i` falls during an open-load report, status stays pulled and is released on the T_POL-th edge that samples `cmd_i` low.
- R8: With `out_hi_i` high, status is pulled on the T_STK-th edge that samples `cmd_i` low after a falling edge of `cmd_i`. The pull ends as soon as `cmd_i` goes high.
- R9: With `stat_dis_i` high, `stat_hiz_o` is 1 and `stat_pull_o` is 0. Diagnosis goes on, so a fault already detected pulls status in the same cycle that `stat_dis_i` falls.
- R10: While thermal shutdown is active, open-load and output-high faults do not pull status.
- R11: A delay condition that drops out before expiry restarts its count. After `ol_on_i` is interrupted, the full 2+T_DOL edges are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | Switch command, high = on |
| stat_dis_i | input | 1 | High releases the status pin to high impedance |
| ot_i | input | 1 | Junction above shutdown threshold |
| tr_i | input | 1 | Junction cooled below restart threshold |
| trs_i | input | 1 | Junction cooled below status reset threshold |
| uv_i | input | 1 | Supply undervoltage |
| ol_on_i | input | 1 | Load current below open-load threshold while on |
| out_hi_i | input | 1 | Output above off-state threshold |
| gate_o | output | 1 | Gate enable for the power stage |
| stat_pull_o | output | 1 | High drives the open-drain status pin low |
| stat_hiz_o | output | 1 | High means the status pin is disabled (high impedance) |

## Verification
The command acts on the gate in its own cycle. A flag reaches the outputs two edges after it changes for undervoltage, and three edges after for thermal shutdown, restart and status release. An open-load report lands 2+T_DOL edges after its flag rises. The hold after the command falls ends T_POL edges after the fall, and the output-high report lands T_STK edges after it. The bench drives inputs only on falling clock edges and compares against its model a quarter period after each rising edge. The directed checks sample one edge before and on the edge each result is due, so an off-by-one shift in any delay is caught.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  typedef struct packed {
    logic ot;
    logic tr;
    logic trs;
    logic uv;
    logic ol_on;
    logic out_hi;
  } hsd_flags_t;

  localparam int unsigned FLAG_W = $bits(hsd_flags_t);
  // undervoltage assumed until the real flag has crossed the synchronizer
  localparam hsd_flags_t FLAGS_RST = '{ot: 1'b0, tr: 1'b0, trs: 1'b0, uv: 1'b1,
                                       ol_on: 1'b0, out_hi: 1'b0};
endpackage

// File: rtl/hsd_flag_sync.sv
module hsd_flag_sync #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= {2{RST_VAL[i]}};
      else         pipe <= {pipe[0], d_i[i]};
    end
    assign q_o[i] = pipe[1];
  end
endmodule

// File: rtl/hsd_delay_timer.sv
module hsd_delay_timer #(
  parameter int unsigned DELAY = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIM = CW'(DELAY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt <= '0;
    else if (!run_i)     cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LIM);

  // R11
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(run_i));
endmodule

// File: rtl/hsd_switch_diag.sv
module hsd_switch_diag
  import hsd_pkg::*;
#(
  parameter int unsigned T_SDL = 20,
  parameter int unsigned T_DOL = 200,
  parameter int unsigned T_POL = 500,
  parameter int unsigned T_STK = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic stat_dis_i,
  input  logic ot_i,
  input  logic tr_i,
  input  logic trs_i,
  input  logic uv_i,
  input  logic ol_on_i,
  input  logic out_hi_i,
  output logic gate_o,
  output logic stat_pull_o,
  output logic stat_hiz_o
);
  hsd_flags_t raw, flg;

  assign raw = '{ot: ot_i, tr: tr_i, trs: trs_i, uv: uv_i,
                 ol_on: ol_on_i, out_hi: out_hi_i};

  hsd_flag_sync #(.W(FLAG_W), .RST_VAL(FLAGS_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(flg)
  );

  logic cmd_q, fall;
  logic tsd_q, therm_rpt_q, pol_act_q, armed_q;
  logic sdl_done, dol_done, pol_done, stk_done;
  logic run_sdl, run_dol, run_pol, run_stk, pol_start;
  logic pull_th, pull_ol, pull_stk;

  assign fall = cmd_q & ~cmd_i;

  // priority: undervoltage, then thermal, then load faults
  assign run_sdl   = tsd_q & cmd_i & ~flg.uv;
  assign run_dol   = cmd_i & ~flg.uv & ~tsd_q & flg.ol_on;
  assign pol_start = fall & dol_done & ~flg.uv & ~tsd_q;
  assign run_pol   = (pol_act_q | pol_start) & ~cmd_i & ~flg.uv;
  assign run_stk   = (armed_q | fall) & ~cmd_i & flg.out_hi & ~flg.uv;

  hsd_delay_timer #(.DELAY(T_SDL)) u_sdl (.clk_i, .rst_ni, .run_i(run_sdl), .done_o(sdl_done));
  hsd_delay_timer #(.DELAY(T_DOL)) u_dol (.clk_i, .rst_ni, .run_i(run_dol), .done_o(dol_done));
  hsd_delay_timer #(.DELAY(T_POL)) u_pol (.clk_i, .rst_ni, .run_i(run_pol), .done_o(pol_done));
  hsd_delay_timer #(.DELAY(T_STK)) u_stk (.clk_i, .rst_ni, .run_i(run_stk), .done_o(stk_done));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= 1'b0;
      tsd_q       <= 1'b0;
      therm_rpt_q <= 1'b0;
      pol_act_q   <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      cmd_q <= cmd_i;
      // automatic restart once cooled to the restart flag
      if (flg.ot)      tsd_q <= 1'b1;
      else if (flg.tr) tsd_q <= 1'b0;
      // status fault holds until the colder release flag
      if (sdl_done)                  therm_rpt_q <= 1'b1;
      else if (flg.trs && !tsd_q)    therm_rpt_q <= 1'b0;
      if (cmd_i || flg.uv || tsd_q || pol_done) pol_act_q <= 1'b0;
      else if (pol_start)                       pol_act_q <= 1'b1;
      if (cmd_i || flg.uv) armed_q <= 1'b0;
      else if (fall)       armed_q <= 1'b1;
    end
  end

  assign pull_th  = (therm_rpt_q | sdl_done) & cmd_i;
  assign pull_ol  = (dol_done | (pol_act_q & ~pol_done)) & ~tsd_q;
  assign pull_stk = stk_done & ~cmd_i & ~tsd_q;

  assign gate_o      = cmd_i & ~flg.uv & ~tsd_q;
  assign stat_hiz_o  = stat_dis_i;
  assign stat_pull_o = ~stat_dis_i & ~flg.uv & (pull_th | pull_ol | pull_stk);

  // R3
  uv_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg.uv |-> (!gate_o && !stat_pull_o));
  // R4
  ot_forces_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flg.ot) |-> !gate_o);
  // R5
  therm_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(therm_rpt_q) |-> $past(flg.trs));
  // R6
  ol_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_ol) |-> $past(cmd_i));
  // R8
  stk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_stk) |-> $past(!cmd_i));
  // R9
  stat_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stat_pull_o, stat_hiz_o}));
endmodule

// File: tb/hsd_switch_diag_tb.sv
module hsd_switch_diag_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_SDL = 20;
  localparam int T_DOL = 200;
  localparam int T_POL = 500;
  localparam int T_STK = 200;
  localparam int OT = 5, TR = 4, TRS = 3, UV = 2, OL = 1, OH = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd = 1'b1, dis = 1'b0, ot = 1'b0, tr = 1'b0, trs = 1'b0;
  logic uv = 1'b0, ol = 1'b0, oh = 1'b0;
  logic gate, pull, hiz;

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  hsd_switch_diag #(.T_SDL(T_SDL), .T_DOL(T_DOL), .T_POL(T_POL), .T_STK(T_STK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .stat_dis_i(dis), .ot_i(ot), .tr_i(tr),
    .trs_i(trs), .uv_i(uv), .ol_on_i(ol), .out_hi_i(oh),
    .gate_o(gate), .stat_pull_o(pull), .stat_hiz_o(hiz)
  );

  // behavioural reference: flag delay queue plus streak counters
  bit [5:0] fq[$] = '{6'b000100, 6'b000100};
  bit m_cmdq = 0, m_tsd = 0, m_trpt = 0, m_pol_act = 0, m_armed = 0;
  int n_sdl = 0, n_dol = 0, n_pol = 0, n_stk = 0;

  function automatic int step_cnt(int c, bit run, int lim);
    if (!run) return 0;
    return (c >= lim) ? lim : c + 1;
  endfunction

  task automatic model_step();
    bit [5:0] f = fq[0];
    bit u = f[UV];
    bit fall = m_cmdq && !cmd;
    bit sd = (n_sdl == T_SDL), dd = (n_dol == T_DOL), pd = (n_pol == T_POL);
    bit pstart = fall && dd && !u && !m_tsd;
    int a = step_cnt(n_sdl, m_tsd && cmd && !u, T_SDL);
    int b = step_cnt(n_dol, cmd && !u && !m_tsd && f[OL], T_DOL);
    int c = step_cnt(n_pol, (m_pol_act || pstart) && !cmd && !u, T_POL);
    int d = step_cnt(n_stk, (m_armed || fall) && !cmd && f[OH] && !u, T_STK);
    bit ntrpt = sd ? 1'b1 : ((f[TRS] && !m_tsd) ? 1'b0 : m_trpt);
    bit npol = (cmd || u || m_tsd || pd) ? 1'b0 : (pstart ? 1'b1 : m_pol_act);
    bit narm = (cmd || u) ? 1'b0 : (fall ? 1'b1 : m_armed);
    bit ntsd = f[OT] ? 1'b1 : (f[TR] ? 1'b0 : m_tsd);
    n_sdl = a; n_dol = b; n_pol = c; n_stk = d;
    m_trpt = ntrpt; m_pol_act = npol; m_armed = narm; m_tsd = ntsd; m_cmdq = cmd;
    void'(fq.pop_front());
    fq.push_back({ot, tr, trs, uv, ol, oh});
  endtask

  function automatic bit exp_gate();
    return cmd && !fq[0][UV] && !m_tsd;
  endfunction

  function automatic bit exp_pull();
    bit th = (m_trpt || n_sdl == T_SDL) && cmd;
    bit ld = ((n_dol == T_DOL) || (m_pol_act && n_pol != T_POL)) && !m_tsd;
    bit sk = (n_stk == T_STK) && !cmd && !m_tsd;
    return !dis && !fq[0][UV] && (th || ld || sk);
  endfunction

  task automatic check(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) model_step();
    #(CLK_PERIOD / 4);
    if (!finished) begin
      check(gate, exp_gate(), cur_req, "gate model");
      check(pull, exp_pull(), cur_req, "pull model");
      check(hiz, dis, cur_req, "hiz model");
    end
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD / 4 + 1);
  endtask

  task automatic drive_at_neg();
    @(negedge clk);
  endtask

  initial begin
    // R1: reset holds gate off even with cmd high
    edges(3);
    check(gate, 1'b0, "R1", "gate in reset");
    check(pull, 1'b0, "R1", "pull in reset");
    drive_at_neg(); rst_n = 1'b1;
    edges(1);
    check(gate, 1'b0, "R1", "gate first edge after reset");
    edges(1);
    cur_req = "R2";
    check(gate, 1'b1, "R2", "gate follows cmd high");
    drive_at_neg(); cmd = 1'b0; #1;
    check(gate, 1'b0, "R2", "gate follows cmd low");
    check(pull, 1'b0, "R2", "no pull normal");
    drive_at_neg(); cmd = 1'b1; edges(4);

    // R3
    cur_req = "R3";
    drive_at_neg(); uv = 1'b1; ol = 1'b1;
    edges(1); check(gate, 1'b1, "R3", "gate one edge after uv");
    edges(1); check(gate, 1'b0, "R3", "gate two edges after uv");
    edges(T_DOL + 10); check(pull, 1'b0, "R3", "no pull in uv");
    drive_at_neg(); uv = 1'b0; ol = 1'b0; edges(6);

    // R6 and R7
    cur_req = "R6";
    drive_at_neg(); ol = 1'b1;
    edges(2 + T_DOL - 1); check(pull, 1'b0, "R6", "open load one edge early");
    edges(1); check(pull, 1'b1, "R6", "open load due");
    cur_req = "R7";
    drive_at_neg(); cmd = 1'b0; #1;
    check(pull, 1'b1, "R7", "pull held at fall");
    edges(T_POL - 1); check(pull, 1'b1, "R7", "pull held before tPOL");
    edges(1); check(pull, 1'b0, "R7", "released at tPOL");
    drive_at_neg(); ol = 1'b0; cmd = 1'b1; edges(6);

    // R11
    cur_req = "R11";
    drive_at_neg(); ol = 1'b1; edges(100);
    drive_at_neg(); ol = 1'b0; edges(5);
    drive_at_neg(); ol = 1'b1;
    edges(2 + T_DOL - 1); check(pull, 1'b0, "R11", "restarted count one edge early");
    edges(1); check(pull, 1'b1, "R11", "restarted count due");
    drive_at_neg(); ol = 1'b0; edges(6);

    // R8 and R9
    cur_req = "R8";
    drive_at_neg(); oh = 1'b1; edges(5);
    check(pull, 1'b0, "R8", "output high with cmd high");
    drive_at_neg(); cmd = 1'b0;
    edges(T_STK - 1); check(pull, 1'b0, "R8", "stuck one edge early");
    edges(1); check(pull, 1'b1, "R8", "stuck due");
    cur_req = "R9";
    drive_at_neg(); dis = 1'b1; #1;
    check(hiz, 1'b1, "R9", "hiz when disabled");
    check(pull, 1'b0, "R9", "no pull when disabled");
    edges(20);
    drive_at_neg(); dis = 1'b0; #1;
    check(pull, 1'b1, "R9", "diagnosis kept while disabled");
    cur_req = "R8";
    drive_at_neg(); cmd = 1'b1; #1;
    check(pull, 1'b0, "R8", "cmd high ends stuck pull");
    drive_at_neg(); oh = 1'b0; edges(6);

    // R4 and R5
    cur_req = "R4";
    drive_at_neg(); ot = 1'b1;
    edges(2); check(gate, 1'b1, "R4", "gate two edges after ot");
    edges(1); check(gate, 1'b0, "R4", "gate off third edge");
    cur_req = "R5";
    edges(T_SDL - 1); check(pull, 1'b0, "R5", "thermal status early");
    edges(1); check(pull, 1'b1, "R5", "thermal status due");
    drive_at_neg(); ot = 1'b0; tr = 1'b1;
    cur_req = "R4";
    edges(2); check(gate, 1'b0, "R4", "still off before restart");
    edges(1); check(gate, 1'b1, "R4", "restart third edge");
    cur_req = "R5";
    check(pull, 1'b1, "R5", "status held after restart");
    edges(10);
    drive_at_neg(); trs = 1'b1;
    edges(2); check(pull, 1'b1, "R5", "status before release");
    edges(1); check(pull, 1'b0, "R5", "status released");
    drive_at_neg(); tr = 1'b0; trs = 1'b0; cmd = 1'b0; ot = 1'b1;
    edges(T_SDL + 20); check(pull, 1'b0, "R5", "no thermal pull with cmd low");
    drive_at_neg(); ot = 1'b0; tr = 1'b1; edges(6);
    drive_at_neg(); tr = 1'b0; cmd = 1'b1; edges(6);

    // R10
    cur_req = "R10";
    drive_at_neg(); oh = 1'b1; ot = 1'b1; edges(3);
    drive_at_neg(); cmd = 1'b0;
    edges(T_STK + 5); check(pull, 1'b0, "R10", "stuck masked in shutdown");
    drive_at_neg(); ot = 1'b0; tr = 1'b1;
    edges(3); check(pull, 1'b1, "R10", "stuck shown after restart");
    drive_at_neg(); tr = 1'b0; oh = 1'b0; cmd = 1'b1; edges(10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule